// File: doc/BRIEF.md
# DS3 C-bit Channel Monitor

This block watches the 21 C bits that arrive in each received DS3 M-frame and turns them into three kinds of status. In the stuffed-multiplex mode, used when the C bits act as stuff indicators, it looks in each of the seven subframes for a loopback request. A request is a third C bit that disagrees with the two C bits before it, and it must persist for several frames before it is reported. In C-bit parity mode it receives the far-end alarm and control (FEAC) channel, which is carried one bit per frame in the third C bit of the frame. It accepts a 6-bit code only after the same 16-bit word has arrived several times in a row.

In both modes it also tracks whether the first C bit of each frame is steadily 1. That identifies a far end running C-bit parity. Each flag has its own set and clear persistence.

The framer upstream presents each C bit as a strobe with a data bit and its index (1 to 21). It then pulses a frame strobe at the end of each M-frame. All decisions are made at frame boundaries, and each result is registered.

Top module: `ds3_cbit_monitor`

## Requirements
- R1: After a synchronous reset all outputs are 0: the seven loopback flags, the C1 identification flag, the FEAC valid pulse and the FEAC code.
- R2: With mode_cbp = 0, loopback flag bit y-1 (for y = 1..7) sets once 5 consecutive frames each have C bit 3y different from both C bit 3y-2 and C bit 3y-1. The flag is visible on the second clock edge after the frame strobe.
- R3: A single frame that lacks that loopback pattern restarts the count, so 4 pattern frames, then one clean frame, then 4 more pattern frames leave the flag at 0.
- R4: A set loopback flag clears only after 5 consecutive frames in which that subframe's third C bit does not differ from both earlier ones. After 4 such frames it is still 1.
- R5: Each subframe is judged on its own C bits: a pattern in one subframe never sets or clears another subframe's flag.
- R6: The C1 identification flag sets after C bit 1 has been 1 in 8 consecutive frames, and changes only on the clock edge that follows a frame's evaluation.
- R7: The C1 identification flag clears after C bit 1 has been 0 in 3 consecutive frames. A single frame with C bit 1 = 1 restarts that count.
- R8: With mode_cbp = 1, C bit 3 of each frame is one FEAC bit. A word, in arrival order, is eight 1s, then 0, then code bits x0..x5, then 0. After the fourth identical consecutive word, feac_vld pulses for one cycle and feac_code = {x5..x0}.
- R9: Only three repeats, or a run broken by a different word or by 16 bits without a valid word, give no pulse. Counting restarts at the breaking word.
- R10: feac_code holds its value until the next acceptance. Further repeats of an already accepted word give no additional pulse.
- R11: In C-bit parity mode the loopback flags are held at 0. In the stuffed-multiplex mode feac_vld stays 0 and feac_code is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_cbp | input | 1 | 1 = C-bit parity mode, 0 = stuffed-multiplex mode |
| cbit_vld | input | 1 | Strobe: a C bit is present on cbit_data |
| cbit_data | input | 1 | Value of the received C bit |
| cbit_idx | input | 5 | Index of the C bit within the M-frame, 1 to 21 |
| frame_strobe | input | 1 | One-cycle pulse at the end of each M-frame |
| lb_flag | output | 7 | Loopback request per subframe, bit y-1 for subframe y |
| c1_id | output | 1 | C-bit parity identification from C bit 1 |
| feac_vld | output | 1 | One-cycle pulse when a FEAC word is accepted |
| feac_code | output | 6 | Last accepted FEAC code {x5..x0} |

## Verification
The bench builds the block with its default parameters: 5 frames of loopback persistence, 8 and 3 frames for C1 set and clear, and a 16-bit FEAC word that needs 4 repeats. A frame costs about 25 clock cycles, so these values put both edges of every count within reach: one frame short of each threshold and exactly at it, for both the loopback and C1 flags. They also allow complete four-word FEAC runs, including runs interrupted by a different word.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

    localparam int NUM_CBITS   = 21;
    localparam int SUBFRAMES   = 7;
    localparam int CB_PER_SF   = NUM_CBITS / SUBFRAMES;
    localparam int IDX_W       = 5;
    localparam int FEAC_LEN    = 16;
    localparam int FEAC_CODE_W = 6;

    typedef logic [NUM_CBITS-1:0] cword_t;

    // The three C bits of one subframe, in arrival order.
    typedef struct packed {
        logic first;
        logic second;
        logic third;
    } sf_bits_t;

    // What one received FEAC bit did to the word receiver.
    typedef enum logic [1:0] {
        FE_IDLE  = 2'd0,
        FE_FIRST = 2'd1,
        FE_AGAIN = 2'd2,
        FE_LOST  = 2'd3
    } feac_ev_t;

    function automatic sf_bits_t sf_slice(cword_t w, int unsigned y);
        sf_bits_t s;
        s.first  = w[CB_PER_SF*y];
        s.second = w[CB_PER_SF*y + 1];
        s.third  = w[CB_PER_SF*y + 2];
        return s;
    endfunction

    // Loopback request: the third bit disagrees with both earlier bits.
    function automatic logic lb_pattern(sf_bits_t s);
        return (s.third != s.first) && (s.third != s.second);
    endfunction

endpackage

// File: rtl/cbm_capture.sv
module cbm_capture
    import cbm_pkg::*;
#(
    parameter int NBITS = NUM_CBITS,
    parameter int IW    = IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cbit_vld,
    input  logic             cbit_data,
    input  logic [IW-1:0]    cbit_idx,
    input  logic             frame_strobe,
    output logic             frame_done,
    output logic [NBITS-1:0] frame_word
);

    logic [NBITS-1:0] acc_q;
    logic [NBITS-1:0] merged;

    // A bit arriving in the same cycle as the strobe still joins its frame.
    always_comb begin
        merged = acc_q;
        for (int i = 0; i < NBITS; i++) begin
            if (cbit_vld && (cbit_idx == IW'(i + 1)))
                merged[i] = cbit_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q      <= '0;
            frame_word <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= frame_strobe;
            if (frame_strobe) begin
                frame_word <= merged;
                acc_q      <= '0;
            end else begin
                acc_q      <= merged;
            end
        end
    end

endmodule

// File: rtl/cbm_persist.sv
module cbm_persist #(
    parameter int SET_N = 5,
    parameter int CLR_N = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic tick,
    input  logic cond,
    output logic flag
);

    localparam int MAXN = (SET_N > CLR_N) ? SET_N : CLR_N;
    localparam int CW   = $clog2(MAXN + 1);
    localparam logic [CW-1:0] SET_LAST = CW'(SET_N - 1);
    localparam logic [CW-1:0] CLR_LAST = CW'(CLR_N - 1);

    logic [CW-1:0] run_q;
    logic [CW-1:0] need_last;

    assign need_last = cond ? SET_LAST : CLR_LAST;

    // run_q counts consecutive ticks whose condition opposes the flag.
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            flag  <= 1'b0;
            run_q <= '0;
        end else if (tick) begin
            if (cond != flag) begin
                if (run_q == need_last) begin
                    flag  <= cond;
                    run_q <= '0;
                end else begin
                    run_q <= run_q + CW'(1);
                end
            end else begin
                run_q <= '0;
            end
        end
    end

endmodule

// File: rtl/cbm_loopback.sv
module cbm_loopback
    import cbm_pkg::*;
#(
    parameter int PERSIST = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 tick,
    input  cword_t               word,
    output logic [SUBFRAMES-1:0] lb_flag
);

    for (genvar g = 0; g < SUBFRAMES; g++) begin : g_sf
        logic req;
        assign req = lb_pattern(sf_slice(word, g));

        cbm_persist #(
            .SET_N(PERSIST),
            .CLR_N(PERSIST)
        ) u_persist (
            .clk (clk),
            .rst (rst),
            .en  (en),
            .tick(tick),
            .cond(req),
            .flag(lb_flag[g])
        );
    end

endmodule

// File: rtl/cbm_feac_rx.sv
module cbm_feac_rx
    import cbm_pkg::*;
#(
    parameter int LEN    = FEAC_LEN,
    parameter int CODE_W = FEAC_CODE_W,
    parameter int REPEAT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              tick,
    input  logic              bit_in,
    output logic              vld,
    output logic [CODE_W-1:0] code
);

    localparam int ONES  = LEN - CODE_W - 2;
    localparam int POS_W = $clog2(LEN);
    localparam int REP_W = $clog2(REPEAT + 1);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(LEN - 1);
    localparam logic [REP_W-1:0] REP_MAX  = REP_W'(REPEAT);
    localparam logic [REP_W-1:0] REP_PRE  = REP_W'(REPEAT - 1);

    logic [LEN-1:0]    sh_q, sh_n;
    logic [POS_W-1:0]  pos_q;
    logic [REP_W-1:0]  rep_q;
    logic [CODE_W-1:0] last_q;
    logic [CODE_W-1:0] cand;
    logic              hit;
    feac_ev_t          ev;

    // Newest bit enters at the top, so the oldest (the flag) sits at bit 0.
    assign sh_n = {bit_in, sh_q[LEN-1:1]};
    assign hit  = (&sh_n[ONES-1:0]) && !sh_n[ONES] && !sh_n[LEN-1];
    assign cand = sh_n[LEN-2:ONES+1];

    always_comb begin
        if (hit)
            ev = ((pos_q == POS_LAST) && (rep_q != '0) && (cand == last_q))
                 ? FE_AGAIN : FE_FIRST;
        else if (pos_q == POS_LAST)
            ev = FE_LOST;
        else
            ev = FE_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            sh_q   <= '0;
            pos_q  <= '0;
            rep_q  <= '0;
            last_q <= '0;
            code   <= '0;
            vld    <= 1'b0;
        end else begin
            vld <= 1'b0;
            if (tick) begin
                sh_q <= sh_n;
                case (ev)
                    FE_FIRST: begin
                        pos_q  <= '0;
                        last_q <= cand;
                        rep_q  <= REP_W'(1);
                    end
                    FE_AGAIN: begin
                        pos_q  <= '0;
                        last_q <= cand;
                        if (rep_q != REP_MAX)
                            rep_q <= rep_q + REP_W'(1);
                        if (rep_q == REP_PRE) begin
                            vld  <= 1'b1;
                            code <= cand;
                        end
                    end
                    FE_LOST: rep_q <= '0;
                    default: pos_q <= pos_q + POS_W'(1);
                endcase
            end
        end
    end

endmodule

// File: rtl/ds3_cbit_monitor.sv
module ds3_cbit_monitor
    import cbm_pkg::*;
#(
    parameter int LB_PERSIST  = 5,
    parameter int C1_SET_N    = 8,
    parameter int C1_CLR_N    = 3,
    parameter int FEAC_REPEAT = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   mode_cbp,
    input  logic                   cbit_vld,
    input  logic                   cbit_data,
    input  logic [IDX_W-1:0]       cbit_idx,
    input  logic                   frame_strobe,
    output logic [SUBFRAMES-1:0]   lb_flag,
    output logic                   c1_id,
    output logic                   feac_vld,
    output logic [FEAC_CODE_W-1:0] feac_code
);

    localparam int C1_POS   = 0;
    localparam int FEAC_POS = 2;

    logic   frame_done;
    cword_t frame_word;

    cbm_capture #(
        .NBITS(NUM_CBITS),
        .IW   (IDX_W)
    ) u_capture (
        .clk         (clk),
        .rst         (rst),
        .cbit_vld    (cbit_vld),
        .cbit_data   (cbit_data),
        .cbit_idx    (cbit_idx),
        .frame_strobe(frame_strobe),
        .frame_done  (frame_done),
        .frame_word  (frame_word)
    );

    cbm_loopback #(
        .PERSIST(LB_PERSIST)
    ) u_loopback (
        .clk    (clk),
        .rst    (rst),
        .en     (!mode_cbp),
        .tick   (frame_done),
        .word   (frame_word),
        .lb_flag(lb_flag)
    );

    cbm_persist #(
        .SET_N(C1_SET_N),
        .CLR_N(C1_CLR_N)
    ) u_c1 (
        .clk (clk),
        .rst (rst),
        .en  (1'b1),
        .tick(frame_done),
        .cond(frame_word[C1_POS]),
        .flag(c1_id)
    );

    cbm_feac_rx #(
        .LEN   (FEAC_LEN),
        .CODE_W(FEAC_CODE_W),
        .REPEAT(FEAC_REPEAT)
    ) u_feac (
        .clk   (clk),
        .rst   (rst),
        .en    (mode_cbp),
        .tick  (frame_done),
        .bit_in(frame_word[FEAC_POS]),
        .vld   (feac_vld),
        .code  (feac_code)
    );

endmodule

// File: rtl/ds3_cbit_monitor_chk.sv
module ds3_cbit_monitor_chk #(
    parameter int NSF    = 7,
    parameter int CODE_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              mode_cbp,
    input logic              frame_done,
    input logic [NSF-1:0]    lb_flag,
    input logic              c1_id,
    input logic              feac_vld,
    input logic [CODE_W-1:0] feac_code
);

    p_lb_zero_cbp_r11: assert property (@(posedge clk) disable iff (rst)
        mode_cbp |=> (lb_flag == '0));

    p_feac_quiet_m23_r11: assert property (@(posedge clk) disable iff (rst)
        !mode_cbp |=> (!feac_vld && feac_code == '0));

    p_lb_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!frame_done && !mode_cbp) |=> $stable(lb_flag));

    p_c1_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !frame_done |=> $stable(c1_id));

    p_feac_single_r10: assert property (@(posedge clk) disable iff (rst)
        feac_vld |=> !feac_vld);

    p_code_hold_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_cbp) && !feac_vld) |-> $stable(feac_code));

endmodule

bind ds3_cbit_monitor ds3_cbit_monitor_chk #(
    .NSF   (cbm_pkg::SUBFRAMES),
    .CODE_W(cbm_pkg::FEAC_CODE_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_cbp  (mode_cbp),
    .frame_done(frame_done),
    .lb_flag   (lb_flag),
    .c1_id     (c1_id),
    .feac_vld  (feac_vld),
    .feac_code (feac_code)
);

// File: tb/ds3_cbit_monitor_tb_top.sv
module ds3_cbit_monitor_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_cbp = 1'b0;
    logic       cbit_vld = 1'b0;
    logic       cbit_data = 1'b0;
    logic [4:0] cbit_idx = '0;
    logic       frame_strobe = 1'b0;
    logic [6:0] lb_flag;
    logic       c1_id;
    logic       feac_vld;
    logic [5:0] feac_code;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    ds3_cbit_monitor dut_i (
        .clk         (clk),
        .rst         (rst),
        .mode_cbp    (mode_cbp),
        .cbit_vld    (cbit_vld),
        .cbit_data   (cbit_data),
        .cbit_idx    (cbit_idx),
        .frame_strobe(frame_strobe),
        .lb_flag     (lb_flag),
        .c1_id       (c1_id),
        .feac_vld    (feac_vld),
        .feac_code   (feac_code)
    );

    always @(negedge clk) if (!rst && feac_vld) pulses++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [20:0] lb_frame(input logic [6:0] m);
        logic [20:0] w = '0;
        for (int y = 0; y < 7; y++) w[3*y+2] = m[y];
        return w;
    endfunction

    task automatic send_frame(input logic [20:0] w);
        for (int i = 1; i <= 21; i++) begin
            @(negedge clk);
            cbit_vld  = 1'b1;
            cbit_idx  = 5'(i);
            cbit_data = w[i-1];
        end
        @(negedge clk);
        cbit_vld = 1'b0;
        frame_strobe = 1'b1;
        @(negedge clk);
        frame_strobe = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_feac_bit(input logic b);
        logic [20:0] w = '0;
        w[2] = b;
        send_frame(w);
    endtask

    task automatic send_feac_word(input logic [5:0] c);
        for (int i = 0; i < 8; i++) send_feac_bit(1'b1);
        send_feac_bit(1'b0);
        for (int i = 0; i < 6; i++) send_feac_bit(c[i]);
        send_feac_bit(1'b0);
    endtask

    task automatic t_reset;
        chk("R1 lb_flag", int'(lb_flag), 0);
        chk("R1 c1_id", int'(c1_id), 0);
        chk("R1 feac_vld", int'(feac_vld), 0);
        chk("R1 feac_code", int'(feac_code), 0);
    endtask

    task automatic t_lb_set;
        mode_cbp = 1'b0;
        for (int i = 0; i < 4; i++) send_frame(lb_frame(7'b0000100));
        chk("R2 before fifth", int'(lb_flag), 0);
        send_frame(lb_frame(7'b0000100));
        chk("R2 set sub3 / R5 others clear", int'(lb_flag), 4);
    endtask

    task automatic t_lb_break;
        for (int i = 0; i < 4; i++) send_frame(lb_frame(7'b0100100));
        send_frame(lb_frame(7'b0000100));
        for (int i = 0; i < 4; i++) send_frame(lb_frame(7'b0100100));
        chk("R3 broken run", int'(lb_flag), 4);
        send_frame(lb_frame(7'b0100100));
        chk("R3 set after full run / R5", int'(lb_flag), 36);
    endtask

    task automatic t_lb_clear;
        for (int i = 0; i < 4; i++) send_frame(lb_frame(7'b0100000));
        chk("R4 still set after four", int'(lb_flag), 36);
        send_frame(lb_frame(7'b0100000));
        chk("R4 cleared sub3 / R5 sub6 kept", int'(lb_flag), 32);
    endtask

    task automatic t_lb_mode;
        mode_cbp = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11 lb zero in parity mode", int'(lb_flag), 0);
        send_frame(lb_frame(7'b1111111));
        chk("R11 lb ignored in parity mode", int'(lb_flag), 0);
    endtask

    task automatic t_c1;
        logic [20:0] one = 21'h1;
        for (int i = 0; i < 7; i++) send_frame(one);
        chk("R6 before eighth", int'(c1_id), 0);
        send_frame(one);
        chk("R6 set after eight", int'(c1_id), 1);
        repeat (2) send_frame('0);
        send_frame(one);
        repeat (2) send_frame('0);
        chk("R7 restart by a one", int'(c1_id), 1);
        send_frame('0);
        chk("R7 cleared after three", int'(c1_id), 0);
    endtask

    task automatic t_feac_accept;
        int p0 = pulses;
        for (int i = 0; i < 3; i++) send_feac_word(6'b101101);
        chk("R9 three repeats no pulse", pulses - p0, 0);
        send_feac_word(6'b101101);
        chk("R8 pulse on fourth", pulses - p0, 1);
        chk("R8 code", int'(feac_code), 45);
        repeat (2) send_feac_word(6'b101101);
        chk("R10 no extra pulse", pulses - p0, 1);
        chk("R10 code held", int'(feac_code), 45);
    endtask

    task automatic t_feac_break;
        int p0 = pulses;
        repeat (2) send_feac_word(6'b010011);
        send_feac_word(6'b101101);
        repeat (2) send_feac_word(6'b010011);
        chk("R9 broken run no pulse", pulses - p0, 0);
        chk("R10 code stable across run", int'(feac_code), 45);
        repeat (2) send_feac_word(6'b010011);
        chk("R9 run restarts at breaker", pulses - p0, 1);
        chk("R8 new code", int'(feac_code), 19);
    endtask

    task automatic t_feac_mode;
        int p0 = pulses;
        mode_cbp = 1'b0;
        repeat (4) send_feac_word(6'b010011);
        chk("R11 no pulse in mux mode", pulses - p0, 0);
        chk("R11 code zero in mux mode", int'(feac_code), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_lb_set();
        t_lb_break();
        t_lb_clear();
        t_lb_mode();
        t_c1();
        t_feac_accept();
        t_feac_break();
        t_feac_mode();
        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            repeat (190000) @(posedge clk);
        join_any
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule